// File: doc/BRIEF.md
# DMA request and acknowledge handshake unit

This unit is the front end of one DMA channel. It brings the external request input into the clock domain and decides whether a transfer is being requested. It then drives the acknowledge strobe back to the requesting device during the bus phase the channel is set up for. It also tells the bus sequencer whether to give up the bus after each unit transfer or to keep it for the next one.

Four mode bits control the unit:

- **Acknowledge phase:** the acknowledge goes out in the read phase or in the write phase of a dual-address transfer.
- **Acknowledge polarity:** the acknowledge is active-high or active-low.
- **Request detection:** a low level or a falling edge counts as a request.
- **Bus mode:** cycle-steal or burst.

On a channel built without external pins (`HAS_PINS = 0`), the first three bits are ignored. Reset and standby both clear all four bits.

The control FSM has three states:

- **ST_IDLE:** no transfer is in progress and the bus is not held.
- **ST_ACTIVE:** a unit transfer is in progress.
- **ST_HOLD:** a burst is between transfers and the bus is still held.

The transitions are:

- **start:** ST_IDLE or ST_HOLD goes to ST_ACTIVE when a request is detected and the sequencer raises a read or write phase.
- **steal_end:** ST_ACTIVE goes to ST_IDLE on `xfer_end` in cycle-steal mode, or when the terminal count is reached.
- **burst_next:** ST_ACTIVE goes to ST_HOLD on `xfer_end` in burst mode when the terminal count has not been reached.
- **burst_stop:** ST_HOLD goes to ST_IDLE when no request is detected any more.

Top module: `dma_req_ack_unit`

## Requirements
- R1: After reset, `req_pending` and `hold_bus` are 0, and `ack_pin` is 0, which is the inactive level of the default active-high polarity.
- R2: With `mode_in[2]`=0 (level detection), `req_pending` follows the synchronized request pin while no transfer is in progress. It is 1 a few cycles after the pin goes low and 0 a few cycles after the pin goes high. After a unit transfer the request is evaluated again.
- R3: With `mode_in[2]`=1 (edge detection), a falling edge on the pin latches a request. The latched request stays pending after the pin returns high, and it is cleared when the acknowledge for that transfer is issued.
- R4: In a dual-address transfer (`dual_addr`=1), `mode_in[0]`=0 asserts the acknowledge only while `rd_phase` is 1. `mode_in[0]`=1 asserts it only while `wr_phase` is 1.
- R5: In single-address mode (`dual_addr`=0), the acknowledge is asserted during either phase, whatever the value of `mode_in[0]`.
- R6: `mode_in[1]`=0 makes the acknowledge active-high and `mode_in[1]`=1 makes it active-low. Outside the acknowledged phase, `ack_pin` drives the inactive level.
- R7: With `mode_in[3]`=0 (cycle-steal), `hold_bus` is always 0.
- R8: With `mode_in[3]`=1 (burst), `hold_bus` is 1 during a transfer and between transfers while the request is still detected. It drops when the request is withdrawn or when `tc_reached` is 1.
- R9: A standby pulse clears all four mode bits to 0. Standby takes priority over a write in the same cycle.
- R10: A channel with `HAS_PINS`=0 ignores `mode_in[0]`, `mode_in[1]` and `mode_in[2]`. It acts as though they were 0: read-phase acknowledge, active-high, level detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Clears the mode bits |
| mode_wr | input | 1 | Loads `mode_in` into the mode register |
| mode_in | input | 4 | Mode bits: [0] acknowledge in write phase, [1] acknowledge active-low, [2] edge detection, [3] burst |
| req_pin | input | 1 | Raw external request, active low, asynchronous |
| rd_phase | input | 1 | Sequencer is in the read cycle |
| wr_phase | input | 1 | Sequencer is in the write cycle |
| dual_addr | input | 1 | 1 = dual-address transfer, 0 = single-address transfer |
| xfer_end | input | 1 | Last cycle of a unit transfer |
| tc_reached | input | 1 | Transfer count is used up |
| req_pending | output | 1 | A request is waiting to be served |
| hold_bus | output | 1 | Keep the bus after this transfer |
| ack_pin | output | 1 | Acknowledge strobe to the device |

## Verification
The assertions check these rules on every cycle:

- The acknowledge is never asserted outside its selected phase.
- The idle acknowledge level always matches the polarity bit.
- Cycle-steal mode never holds the bus.
- A terminal-count end always returns the FSM to ST_IDLE.
- Standby always clears the mode bits.
- A latched edge request clears once it has been acknowledged.

Only the bench scenarios can show the behaviours that depend on the sequence of stimulus:

- The request is detected through the synchronizer.
- An edge request stays pending after the pin has gone high again.
- A burst continues and then stops when the request is withdrawn.
- A channel without pins ignores the pin-related bits.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
    typedef struct packed {
        logic burst;
        logic req_edge;
        logic ack_low;
        logic ack_wr;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } hs_state_t;
endpackage

// File: rtl/dma_hs_mode_reg.sv
module dma_hs_mode_reg
    import dma_hs_pkg::*;
#(
    parameter bit HAS_PINS = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       mode_wr,
    input  logic [3:0] mode_in,
    output mode_t      mode_eff
);
    localparam logic PIN_MASK = HAS_PINS ? 1'b1 : 1'b0;

    mode_t mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode_q <= '0;
        else if (standby)  mode_q <= '0;
        else if (mode_wr)  mode_q <= mode_t'(mode_in);
    end

    always_comb begin
        mode_eff.burst    = mode_q.burst;
        mode_eff.req_edge = mode_q.req_edge & PIN_MASK;
        mode_eff.ack_low  = mode_q.ack_low  & PIN_MASK;
        mode_eff.ack_wr   = mode_q.ack_wr   & PIN_MASK;
    end

    // R9: standby leaves every mode bit at 0
    a_r9_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (mode_q == '0));
endmodule

// File: rtl/dma_hs_req_detect.sv
module dma_hs_req_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pin,
    input  logic req_edge,
    input  logic ack_act,
    output logic req_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic prev_q;
    logic latch_q;
    logic fall;

    genvar i;
    generate
        for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= req_pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign fall = prev_q & ~chain[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= chain[LAST];
            if (fall && req_edge) latch_q <= 1'b1;
            else if (ack_act)     latch_q <= 1'b0;
        end
    end

    assign req_det = req_edge ? latch_q : ~chain[LAST];

    // R3: an acknowledged edge request is consumed
    a_r3_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_act && !fall) |=> !latch_q);
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_det,
    input  logic rd_phase,
    input  logic wr_phase,
    input  logic dual_addr,
    input  logic xfer_end,
    input  logic tc_reached,
    input  logic burst,
    input  logic ack_wr,
    output logic ack_act,
    output logic req_pending,
    output logic hold_bus
);
    hs_state_t state_q, state_d;
    logic start;
    logic in_xfer;
    logic phase_hit;

    assign start = (state_q != ST_ACTIVE) && req_det && (rd_phase || wr_phase);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ACTIVE;
            ST_ACTIVE: if (xfer_end) state_d = (burst && !tc_reached) ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (start)         state_d = ST_ACTIVE;
                else if (!req_det) state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_xfer     = (state_q == ST_ACTIVE) || start;
        phase_hit   = dual_addr ? (ack_wr ? wr_phase : rd_phase) : (rd_phase || wr_phase);
        ack_act     = in_xfer && phase_hit;
        req_pending = req_det && (state_q != ST_ACTIVE);
        hold_bus    = burst && !tc_reached &&
                      (in_xfer || ((state_q == ST_HOLD) && req_det));
    end

    // R4: no acknowledge outside the selected dual-address phase
    a_r4_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_addr && !ack_wr && !rd_phase) |-> !ack_act);
    // R7: cycle-steal never holds the bus
    a_r7_steal_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !burst |-> !hold_bus);
    // R8: terminal count ends the transfer and frees the bus
    a_r8_tc_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && xfer_end && tc_reached) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dma_req_ack_unit.sv
module dma_req_ack_unit
    import dma_hs_pkg::*;
#(
    parameter bit HAS_PINS    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       mode_wr,
    input  logic [3:0] mode_in,
    input  logic       req_pin,
    input  logic       rd_phase,
    input  logic       wr_phase,
    input  logic       dual_addr,
    input  logic       xfer_end,
    input  logic       tc_reached,
    output logic       req_pending,
    output logic       hold_bus,
    output logic       ack_pin
);
    mode_t mode_eff;
    logic  req_det;
    logic  ack_act;

    dma_hs_mode_reg #(.HAS_PINS(HAS_PINS)) u_mode (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .mode_wr(mode_wr), .mode_in(mode_in), .mode_eff(mode_eff)
    );

    dma_hs_req_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .req_pin(req_pin),
        .req_edge(mode_eff.req_edge), .ack_act(ack_act), .req_det(req_det)
    );

    dma_hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_det(req_det),
        .rd_phase(rd_phase), .wr_phase(wr_phase), .dual_addr(dual_addr),
        .xfer_end(xfer_end), .tc_reached(tc_reached),
        .burst(mode_eff.burst), .ack_wr(mode_eff.ack_wr),
        .ack_act(ack_act), .req_pending(req_pending), .hold_bus(hold_bus)
    );

    assign ack_pin = ack_act ^ mode_eff.ack_low;

    // R6: outside any bus phase the pin rests at the inactive level
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_phase || wr_phase) |-> (ack_pin == mode_eff.ack_low));
endmodule

// File: tb/dma_req_ack_unit_test.sv
`timescale 1ns/1ps
module dma_req_ack_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b0, mode_wr = 1'b0;
    logic [3:0] mode_in = 4'd0;
    logic req_pin = 1'b1, rd_phase = 1'b0, wr_phase = 1'b0;
    logic dual_addr = 1'b1, xfer_end = 1'b0, tc_reached = 1'b0;
    logic req_pending, hold_bus, ack_pin;
    logic np_pending, np_hold, np_ack;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    dma_req_ack_unit uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .mode_wr(mode_wr),
        .mode_in(mode_in), .req_pin(req_pin), .rd_phase(rd_phase),
        .wr_phase(wr_phase), .dual_addr(dual_addr), .xfer_end(xfer_end),
        .tc_reached(tc_reached), .req_pending(req_pending),
        .hold_bus(hold_bus), .ack_pin(ack_pin)
    );

    dma_req_ack_unit #(.HAS_PINS(1'b0)) uut_np (
        .clk(clk), .rst_n(rst_n), .standby(standby), .mode_wr(mode_wr),
        .mode_in(mode_in), .req_pin(req_pin), .rd_phase(rd_phase),
        .wr_phase(wr_phase), .dual_addr(dual_addr), .xfer_end(xfer_end),
        .tc_reached(tc_reached), .req_pending(np_pending),
        .hold_bus(np_hold), .ack_pin(np_ack)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic samp;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode_in = m; mode_wr = 1'b1; tick(1); mode_wr = 1'b0;
    endtask

    // unit transfer: read cycle, then write cycle with xfer_end; returns acks
    task automatic xfer(input logic tc, output logic a_rd, output logic a_wr,
                        output logic h_wr);
        rd_phase = 1'b1; samp(); a_rd = ack_pin; tick(1);
        rd_phase = 1'b0; wr_phase = 1'b1; xfer_end = 1'b1; tc_reached = tc;
        samp(); a_wr = ack_pin; h_wr = hold_bus; tick(1);
        wr_phase = 1'b0; xfer_end = 1'b0; tc_reached = 1'b0;
    endtask

    task automatic t_reset;
        samp();
        check("R1 req_pending", req_pending, 1'b0);
        check("R1 hold_bus", hold_bus, 1'b0);
        check("R1 ack_pin", ack_pin, 1'b0);
    endtask

    task automatic t_level_steal;
        logic a, b, h;
        set_mode(4'b0000);
        req_pin = 1'b0; tick(4); samp();
        check("R2 level pending", req_pending, 1'b1);
        dual_addr = 1'b1;
        xfer(1'b0, a, b, h);
        check("R4 ack in read", a, 1'b1);
        check("R4 no ack in write", b, 1'b0);
        check("R7 steal no hold", h, 1'b0);
        samp();
        check("R2 re-evaluated pending", req_pending, 1'b1);
        check("R7 steal idle no hold", hold_bus, 1'b0);
        req_pin = 1'b1; tick(4); samp();
        check("R2 level released", req_pending, 1'b0);
    endtask

    task automatic t_write_phase;
        logic a, b, h;
        set_mode(4'b0001);
        req_pin = 1'b0; tick(4);
        dual_addr = 1'b1;
        rd_phase = 1'b1; samp();
        check("R10 np acks in read", np_ack, 1'b1);
        tick(1); rd_phase = 1'b0; tick(1);
        xfer(1'b0, a, b, h);
        check("R4 write: no ack in read", a, 1'b0);
        check("R4 write: ack in write", b, 1'b1);
        dual_addr = 1'b0;
        xfer(1'b0, a, b, h);
        check("R5 single ack read", a, 1'b1);
        check("R5 single ack write", b, 1'b1);
        dual_addr = 1'b1;
        req_pin = 1'b1; tick(4);
    endtask

    task automatic t_polarity;
        logic a, b, h;
        set_mode(4'b0010);
        samp();
        check("R6 active-low idle high", ack_pin, 1'b1);
        check("R10 np idle ignores polarity", np_ack, 1'b0);
        req_pin = 1'b0; tick(4);
        xfer(1'b0, a, b, h);
        check("R6 active-low ack", a, 1'b0);
        check("R6 active-low inactive in write", b, 1'b1);
        req_pin = 1'b1; tick(4);
        standby = 1'b1; mode_in = 4'b0010; mode_wr = 1'b1; tick(1);
        standby = 1'b0; mode_wr = 1'b0; samp();
        check("R9 standby restores high polarity", ack_pin, 1'b0);
    endtask

    task automatic t_edge;
        logic a, b, h;
        set_mode(4'b0100);
        req_pin = 1'b0; tick(2); req_pin = 1'b1; tick(5); samp();
        check("R3 edge latched after pin high", req_pending, 1'b1);
        check("R10 np level sees no request", np_pending, 1'b0);
        xfer(1'b0, a, b, h);
        check("R3 edge ack", a, 1'b1);
        samp();
        check("R3 latch cleared by ack", req_pending, 1'b0);
    endtask

    task automatic t_burst;
        logic a, b, h;
        set_mode(4'b1000);
        req_pin = 1'b0; tick(4);
        xfer(1'b0, a, b, h);
        check("R8 burst holds during transfer", h, 1'b1);
        samp();
        check("R8 burst holds between transfers", hold_bus, 1'b1);
        xfer(1'b1, a, b, h);
        check("R8 tc drops hold", h, 1'b0);
        samp();
        check("R8 released after tc", hold_bus, 1'b0);
        xfer(1'b0, a, b, h);
        samp();
        check("R8 burst resumed hold", hold_bus, 1'b1);
        req_pin = 1'b1; tick(4); samp();
        check("R8 withdrawn request drops hold", hold_bus, 1'b0);
        check("R2 no pending after withdraw", req_pending, 1'b0);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1; tick(2);
        t_reset();
        t_level_steal();
        t_write_phase();
        t_polarity();
        t_edge();
        t_burst();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule